// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block derives the serial clock of an SPI transfer engine from the module clock. One configuration register holds two divider values and a law-select bit. The linear law gives a serial clock period of 2×(N+1) module clocks. The power-of-two law gives a period of 2^(N+1) module clocks. Beside the serial clock it produces two single-cycle strobes. One marks the edge that leaves the idle level, for the engine's first action of each bit. The other marks the edge that returns to the idle level.

The transfer engine holds `run` high for as long as a transfer lasts. While `run` is low, the serial clock rests at the idle polarity given on `cpol`. The divider setting and the polarity are sampled only in the cycle in which `run` rises, so a register write made during a transfer cannot disturb the running clock. The write takes effect at the next transfer.

Top module: `spi_sclk_gen`

## Requirements
- R1: The register is written when `reg_wr` is high and `reg_addr` equals 0x1C; a write to any other address leaves the divider setting unchanged. Field layout of `reg_wdata`: bits 7:0 linear value, bits 11:8 power-of-two value, bit 12 law select.
- R2: Under the linear law with value N, the serial clock period is 2×(N+1) module clocks, so each level lasts N+1 cycles, for N up to 255.
- R3: Under the power-of-two law with value N, the serial clock period is 2^(N+1) module clocks, so each level lasts 2^N cycles.
- R4: Select bit 12 set chooses the linear law; clear chooses the power-of-two law. Both values are kept in the register whichever law is selected.
- R5: While `run` is low, `sclk` follows `cpol` with one cycle of delay and no strobe is produced.
- R6: Every serial clock period gives exactly one `lead_stb` and one `trail_stb`, each one cycle wide and never both together. `lead_stb` is high in the first cycle after `sclk` leaves the `cpol` level; `trail_stb` is high in the first cycle after it returns.
- R7: The divider setting and polarity are taken from the register and `cpol` in the cycle in which `run` rises. A register write during a transfer affects only the following transfer.
- R8: A linear value of 0 gives the fastest clock: `sclk` changes on every module clock.
- R9: After reset `sclk`, `lead_stb` and `trail_stb` are low and the register is zero, which selects the power-of-two law with N=0 (period of 2 cycles).
- R10: When `run` falls, even in the middle of a level, `sclk` returns to the idle polarity in the next cycle and strobes stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 13 | Register write data: linear value, power-of-two value, law select |
| cpol | input | 1 | Idle level of the serial clock |
| run | input | 1 | High while the transfer engine is active |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe after the edge leaving the idle level |
| trail_stb | output | 1 | One-cycle strobe after the edge returning to the idle level |

## Verification
The hardest case to reach from the ports is a register write that lands while a transfer is already running. The rule is that it must not touch the running clock, yet must govern the next transfer. The stimulus issues that write a few cycles after `run` rises. It then measures the strobe spacing of the running transfer against the old setting, and starts a second transfer with no further write to show that the new setting arrived. A transfer stopped in the middle of a level, a write to a neighbouring address, and a register holding both values with only the select bit changing cover the other corners that are hard to see.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  localparam int unsigned DEF_LIN_W  = 8;
  localparam int unsigned DEF_POW_W  = 4;
  localparam int unsigned DEF_ADDR_W = 8;

endpackage

// File: rtl/sclkdiv_cfg.sv
module sclkdiv_cfg
  import sclkdiv_pkg::*;
#(
  parameter int unsigned LIN_W  = DEF_LIN_W,
  parameter int unsigned POW_W  = DEF_POW_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] OFFSET = 'h1C,
  parameter int unsigned HP_W   = 16,
  localparam int unsigned CFG_W = LIN_W + POW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CFG_W-1:0]  reg_wdata,
  input  logic              start,
  input  logic              active,
  output logic [HP_W-1:0]   half_per
);

  localparam int unsigned SEL_BIT = LIN_W + POW_W;

  logic [LIN_W-1:0] lin_q, lin_n;
  logic [POW_W-1:0] pow_q, pow_n;
  div_law_e         law_q, law_n;
  logic [HP_W-1:0]  hp_q, hp_n;
  logic [HP_W-1:0]  hp_live;
  logic             hit;

  assign hit = reg_wr && (reg_addr == OFFSET);

  // half period from the live register contents
  always_comb begin
    if (law_q == LAW_LINEAR)
      hp_live = HP_W'(lin_q) + HP_W'(1);
    else
      hp_live = HP_W'(1) << pow_q;
  end

  always_comb begin
    lin_n = lin_q;
    pow_n = pow_q;
    law_n = law_q;
    hp_n  = hp_q;
    if (hit) begin
      lin_n = reg_wdata[LIN_W-1:0];
      pow_n = reg_wdata[SEL_BIT-1:LIN_W];
      law_n = div_law_e'(reg_wdata[SEL_BIT]);
    end
    if (start)
      hp_n = hp_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q <= '0;
      pow_q <= '0;
      law_q <= LAW_POW2;
      hp_q  <= HP_W'(1);
    end else begin
      if (hit) begin
        lin_q <= lin_n;
        pow_q <= pow_n;
        law_q <= law_n;
      end
      if (start)
        hp_q <= hp_n;
    end
  end

  assign half_per = hp_q;

  AST_HP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(half_per)); // R7

endmodule

// File: rtl/sclkdiv_count.sv
module sclkdiv_count #(
  parameter int unsigned HP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [HP_W-1:0] half_per,
  output logic            active,
  output logic            start,
  output logic            tick
);

  logic            act_q, act_n;
  logic [HP_W-1:0] cnt_q, cnt_n;
  logic            cnt_en;

  assign start  = run && !act_q;
  assign tick   = act_q && run && (cnt_q == (half_per - HP_W'(1)));
  assign cnt_en = act_q || start;

  always_comb begin
    act_n = run;
    if (!run || start || tick)
      cnt_n = '0;
    else
      cnt_n = cnt_q + HP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_n;
      if (cnt_en)
        cnt_q <= cnt_n;
    end
  end

  assign active = act_q;

  AST_CNT_BELOW_HP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && run) |-> (cnt_q < half_per)); // R2

endmodule

// File: rtl/sclkdiv_edge.sv
module sclkdiv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic active,
  input  logic start,
  input  logic tick,
  input  logic cpol,
  output logic sclk,
  output logic lead_stb,
  output logic trail_stb
);

  logic phase_q, phase_n;
  logic pol_q, pol_n;
  logic sclk_q, sclk_n;
  logic lead_q, lead_n;
  logic trail_q, trail_n;

  always_comb begin
    pol_n   = start ? cpol : pol_q;
    if (!run || start)
      phase_n = 1'b0;
    else if (tick)
      phase_n = !phase_q;
    else
      phase_n = phase_q;
    sclk_n  = (run && active) ? (pol_q ^ phase_n) : cpol;
    lead_n  = tick && !phase_q;
    trail_n = tick && phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      pol_q   <= 1'b0;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      phase_q <= phase_n;
      if (start)
        pol_q <= pol_n;
      sclk_q  <= sclk_n;
      lead_q  <= lead_n;
      trail_q <= trail_n;
    end
  end

  assign sclk      = sclk_q;
  assign lead_stb  = lead_q;
  assign trail_stb = trail_q;

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_q, trail_q})); // R6
  AST_LEAD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> (sclk_q != $past(sclk_q))); // R6
  AST_TRAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    trail_q |-> (sclk_q == pol_q)); // R6

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import sclkdiv_pkg::*;
#(
  parameter int unsigned LIN_W    = DEF_LIN_W,
  parameter int unsigned POW_W    = DEF_POW_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] OFFSET = 'h1C,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned CFG_W   = LIN_W + POW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CFG_W-1:0]  reg_wdata,
  input  logic              cpol,
  input  logic              run,
  output logic              sclk,
  output logic              lead_stb,
  output logic              trail_stb
);

  localparam int unsigned POW_HP_W = 2 ** POW_W;
  localparam int unsigned HP_W     = (POW_HP_W > LIN_W + 1) ? POW_HP_W : LIN_W + 1;

  // reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STG-1:0] rsync_q;
  logic                rst_s_n;

  genvar g;
  generate
    for (g = 0; g < SYNC_STG; g++) begin : g_rsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rsync_q[g] <= 1'b0;
        else if (g == 0)
          rsync_q[g] <= 1'b1;
        else
          rsync_q[g] <= rsync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_s_n = rsync_q[SYNC_STG-1];

  logic [HP_W-1:0] half_per;
  logic            active, start, tick;

  sclkdiv_cfg #(
    .LIN_W(LIN_W), .POW_W(POW_W), .ADDR_W(ADDR_W), .OFFSET(OFFSET), .HP_W(HP_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .start(start), .active(active), .half_per(half_per)
  );

  sclkdiv_count #(.HP_W(HP_W)) u_count (
    .clk(clk), .rst_n(rst_s_n), .run(run), .half_per(half_per),
    .active(active), .start(start), .tick(tick)
  );

  sclkdiv_edge u_edge (
    .clk(clk), .rst_n(rst_s_n), .run(run), .active(active), .start(start),
    .tick(tick), .cpol(cpol), .sclk(sclk), .lead_stb(lead_stb),
    .trail_stb(trail_stb)
  );

  AST_IDLE_CPOL: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(!run && rst_s_n) |-> (sclk == $past(cpol))); // R5
  AST_NO_IDLE_STB: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(!run && rst_s_n) |-> !(lead_stb || trail_stb)); // R10

endmodule

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [12:0] reg_wdata = '0;
  logic        cpol = 1'b0;
  logic        run = 1'b0;
  logic        sclk, lead_stb, trail_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = !clk;

  spi_sclk_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cpol(cpol), .run(run), .sclk(sclk),
    .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  typedef struct {
    int    hp;
    int    leads;
    int    trails;
    bit    cp;
    string req;
  } exp_t;

  exp_t sb[$];

  // bench model of the register
  bit m_sel = 0;
  int m_lin = 0;
  int m_pow = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_hp();
    return m_sel ? (m_lin + 1) : (1 << m_pow);
  endfunction

  task automatic wr(input logic [7:0] a, input bit sel, input int pw, input int ln);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = {sel, 4'(pw), 8'(ln)};
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 8'h1C) begin
      m_sel = sel; m_pow = pw; m_lin = ln;
    end
  endtask

  // driver: run a transfer, push what the monitor must see
  task automatic xfer(input bit cp, input int periods, input int abort_len,
                      input bit mid, input bit msel, input int mpow, input int mlin,
                      input string req);
    exp_t e;
    int rl, t;
    e.hp = model_hp();
    rl = (abort_len > 0) ? abort_len : 2 * periods * e.hp + 1;
    t  = (rl - 1) / e.hp;
    e.leads  = (t + 1) / 2;
    e.trails = t / 2;
    e.cp  = cp;
    e.req = req;
    @(negedge clk);
    cpol = cp;
    @(negedge clk);
    sb.push_back(e);
    run = 1'b1;
    for (int i = 0; i < rl; i++) begin
      if (mid && i == 2) begin
        reg_wr = 1'b1; reg_addr = 8'h1C; reg_wdata = {msel, 4'(mpow), 8'(mlin)};
      end else begin
        reg_wr = 1'b0;
      end
      @(negedge clk);
    end
    run = 1'b0;
    reg_wr = 1'b0;
    if (mid) begin
      m_sel = msel; m_pow = mpow; m_lin = mlin;
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard comparison
  initial begin
    exp_t cur;
    bit in_x = 0;
    bit prev_run = 0;
    int cyc = 0, last_t = 0, nl = 0, nt = 0, bad_iv = 0, bad_lv = 0;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      cyc++;
      if (rst_n) begin
        if (run && !in_x) begin
          if (sb.size() == 0) begin
            chk(0, "R10 unexpected transfer", 0, 1);
          end else begin
            cur = sb.pop_front();
            in_x = 1; last_t = cyc; nl = 0; nt = 0; bad_iv = 0; bad_lv = 0;
          end
        end else if (in_x && run) begin
          if (lead_stb || trail_stb) begin
            if (cyc - last_t != cur.hp) begin
              bad_iv++;
              $display("FAIL %s interval actual=%0d expected=%0d", cur.req, cyc - last_t, cur.hp);
            end
            last_t = cyc;
          end
          if (lead_stb && trail_stb) bad_lv++;               // R6
          if (lead_stb) begin nl++; if (sclk == cur.cp) bad_lv++; end
          if (trail_stb) begin nt++; if (sclk != cur.cp) bad_lv++; end
        end else if (in_x && !run) begin
          chk(nl == cur.leads, {cur.req, " R6 lead count"}, nl, cur.leads);
          chk(nt == cur.trails, {cur.req, " R6 trail count"}, nt, cur.trails);
          chk(bad_iv == 0, {cur.req, " strobe spacing"}, bad_iv, 0);
          chk(bad_lv == 0, {cur.req, " R6 strobe level"}, bad_lv, 0);
          chk(sclk == cur.cp, {cur.req, " R10 idle after stop"}, sclk, cur.cp);
          in_x = 0;
        end else if (!run && (lead_stb || trail_stb)) begin
          chk(0, "R5 strobe while idle", 1, 0);
        end
      end
      prev_run = run;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sclk == 1'b0, "R9 sclk after reset", sclk, 0);
    chk(lead_stb == 1'b0, "R9 lead after reset", lead_stb, 0);
    chk(trail_stb == 1'b0, "R9 trail after reset", trail_stb, 0);

    xfer(0, 3, 0, 0, 0, 0, 0, "R9 default divide");

    wr(8'h1C, 0, 2, 0);   xfer(0, 2, 0, 0, 0, 0, 0, "R3 pow N2");
    wr(8'h1C, 0, 4, 0);   xfer(1, 2, 0, 0, 0, 0, 0, "R3 pow N4 cpol1");
    wr(8'h1C, 0, 7, 0);   xfer(0, 1, 0, 0, 0, 0, 0, "R3 pow N7");
    wr(8'h1C, 1, 0, 3);   xfer(0, 3, 0, 0, 0, 0, 0, "R2 lin N3");
    wr(8'h1C, 1, 0, 5);   xfer(1, 2, 0, 0, 0, 0, 0, "R2 lin N5 cpol1");
    wr(8'h1C, 1, 0, 255); xfer(0, 1, 0, 0, 0, 0, 0, "R2 lin N255");
    wr(8'h1C, 1, 0, 0);   xfer(0, 4, 0, 0, 0, 0, 0, "R8 lin N0");

    wr(8'h1C, 1, 2, 5);   xfer(0, 2, 0, 0, 0, 0, 0, "R4 sel linear");
    wr(8'h1C, 0, 2, 5);   xfer(0, 2, 0, 0, 0, 0, 0, "R4 sel pow2");

    wr(8'h1C, 1, 0, 3);
    wr(8'h18, 1, 0, 0);
    wr(8'h1D, 0, 9, 0);
    xfer(0, 2, 0, 0, 0, 0, 0, "R1 other offsets ignored");

    wr(8'h1C, 0, 1, 0);
    xfer(0, 3, 0, 1, 1, 0, 9, "R7 write during transfer");
    xfer(1, 2, 0, 0, 0, 0, 0, "R7 new setting next transfer");

    wr(8'h1C, 1, 0, 3);
    xfer(0, 0, 6, 0, 0, 0, 0, "R10 stop mid level");

    @(negedge clk); cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R5 idle follows cpol high", sclk, 1);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R5 idle follows cpol low", sclk, 0);

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule